// File: doc/BRIEF.md
# PHY Status Auto-Poll Monitor

This block keeps a fresh copy of an external PHY's status register without software having to ask for it. While its enable input is high it issues read requests for the status register to an MDIO management master. The requests are spaced by a programmable interval. Each good result is kept in a shadow register. The first good read after polling is switched on only loads the shadow. Every good read after that is compared with the shadow, and any difference raises a sticky change flag. The flag drives an interrupt line when interrupts are enabled.

The same MDIO master also serves software. The block sits between the two sources and the master. A software request waiting in the same cycle as a due poll wins. Whichever request wins is copied into a holding register and then offered to the master. With the enable low, no polls are made, and software has the master to itself. The serialisation on the MDIO wires and the host register file live outside this block.

Both the software request port and the master request port follow valid/ready rules. A request is taken on a clock edge where valid and ready are both high. Software may hold `sw_req_valid` as long as it wishes, and the block raises `sw_req_ready` only while no access is in flight. Once `mdio_req_valid` is high, it stays high and its fields stay unchanged until the master takes the request with `mdio_req_ready`. The master ends each access with a one-cycle `mdio_done` pulse.

Top module: `phy_autopoll`

## Requirements
- R1: After reset `status_shadow` is 0, `change_flag` and `irq` are 0, `mdio_req_valid` is 0, and `sw_req_ready` is 1.
- R2: A poll request is a read (`mdio_req_write` = 0) of register address 1 (`mdio_req_reg` = 5'h01) at the PHY address given on `phy_addr`. With polling enabled and nothing in flight, the first poll is issued at once.
- R3: With interval N on `poll_interval`, the next poll request becomes valid on the (N+1)th clock edge after the edge that takes the previous poll's `mdio_done`. In the bench, N = 3 gives 4 low samples of valid between them.
- R4: The first good poll read after polling is enabled loads `status_shadow` and leaves `change_flag` unchanged.
- R5: A later good poll read that differs from the shadow sets `change_flag` and loads the new value into the shadow. A read equal to the shadow sets nothing.
- R6: A poll that ends with `mdio_err` = 1 leaves the shadow and the flag unchanged.
- R7: `change_flag` is sticky. A one-cycle `change_clr` pulse clears it. If a new change is seen in the same cycle as the pulse, the flag stays set.
- R8: `irq` is 1 exactly when `change_flag` is 1 and `irq_en` is 1.
- R9: While `poll_en` is 0 no poll requests are issued, and a poll result arriving then is ignored. Each new enable starts again with a load-only read.
- R10: A software request takes priority over a due poll. Its fields are passed to the master unchanged. `sw_done` pulses in the cycle of its `mdio_done`, and does not pulse for a poll. A software access never changes the shadow.
- R11: While `mdio_req_valid` is 1 and `mdio_req_ready` is 0, the request stays valid and its fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en | input | 1 | Auto-poll enable |
| irq_en | input | 1 | Interrupt enable |
| phy_addr | input | 5 | PHY address used by polls |
| poll_interval | input | 16 | Idle cycles between polls |
| change_clr | input | 1 | Write-one-to-clear pulse for the change flag |
| sw_req_valid | input | 1 | Software request valid |
| sw_req_ready | output | 1 | Software request accepted |
| sw_req_write | input | 1 | Software request is a write |
| sw_req_reg | input | 5 | Software register address |
| sw_req_wdata | input | 16 | Software write data |
| sw_done | output | 1 | Software access finished |
| mdio_req_valid | output | 1 | Request to the MDIO master valid |
| mdio_req_ready | input | 1 | MDIO master accepts the request |
| mdio_req_write | output | 1 | Request is a write |
| mdio_req_phy | output | 5 | Request PHY address |
| mdio_req_reg | output | 5 | Request register address |
| mdio_req_wdata | output | 16 | Request write data |
| mdio_done | input | 1 | MDIO master finished the access |
| mdio_rdata | input | 16 | Read data from the master |
| mdio_err | input | 1 | Read failed its turnaround check |
| status_shadow | output | 16 | Latest good polled status |
| change_flag | output | 1 | Sticky status-change flag |
| irq | output | 1 | Interrupt line |

## Verification
If the load-only state is wrong, the first read after an enable sets `change_flag` when it should not, or a changed later read fails to set it. Either shows at the ports one cycle after that poll's `mdio_done`. A wrong interval count moves the next `mdio_req_valid` off its expected edge, so the request gap shows it within N+1 cycles. Arbitration or ownership faults show up in the very next request, as the wrong fields or a missing `sw_done`, or as the shadow being loaded from a software read.

// File: rtl/phy_autopoll_pkg.sv
package phy_autopoll_pkg;
  localparam int PHY_ADDR_W  = 5;
  localparam int PHY_DATA_W  = 16;
  localparam int PHY_IVL_W   = 16;
  localparam int PHY_STS_REG = 1;

  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_ISSUE = 2'd1,
    ARB_BUSY  = 2'd2
  } arb_state_t;

  typedef enum logic {
    OWN_SW   = 1'b0,
    OWN_POLL = 1'b1
  } arb_owner_t;
endpackage

// File: rtl/phy_poll_timer.sv
module phy_poll_timer #(
  parameter int IVL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_en,
  input  logic             reload,
  input  logic [IVL_W-1:0] interval,
  output logic             poll_due
);
  logic [IVL_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!poll_en) begin
      cnt_q <= '0;
    end else if (reload) begin
      cnt_q <= interval;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign poll_due = poll_en && (cnt_q == '0);
endmodule

// File: rtl/phy_mdio_arbiter.sv
module phy_mdio_arbiter
  import phy_autopoll_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int DATA_W  = 16,
  parameter int STS_REG = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_req_valid,
  output logic              sw_req_ready,
  input  logic              sw_req_write,
  input  logic [ADDR_W-1:0] sw_req_reg,
  input  logic [DATA_W-1:0] sw_req_wdata,
  output logic              sw_done,
  input  logic              poll_due,
  input  logic [ADDR_W-1:0] phy_addr,
  output logic              mdio_req_valid,
  input  logic              mdio_req_ready,
  output logic              mdio_req_write,
  output logic [ADDR_W-1:0] mdio_req_phy,
  output logic [ADDR_W-1:0] mdio_req_reg,
  output logic [DATA_W-1:0] mdio_req_wdata,
  input  logic              mdio_done,
  output logic              poll_done
);
  localparam logic [ADDR_W-1:0] STS_ADDR = ADDR_W'(STS_REG);

  arb_state_t        state_q;
  arb_owner_t        owner_q;
  logic              wr_q;
  logic [ADDR_W-1:0] phy_q;
  logic [ADDR_W-1:0] reg_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      owner_q <= OWN_SW;
      wr_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (state_q)
        ARB_IDLE: begin
          if (sw_req_valid) begin
            owner_q <= OWN_SW;
            wr_q    <= sw_req_write;
            phy_q   <= phy_addr;
            reg_q   <= sw_req_reg;
            wdata_q <= sw_req_wdata;
            state_q <= ARB_ISSUE;
          end else if (poll_due) begin
            owner_q <= OWN_POLL;
            wr_q    <= 1'b0;
            phy_q   <= phy_addr;
            reg_q   <= STS_ADDR;
            wdata_q <= '0;
            state_q <= ARB_ISSUE;
          end
        end
        ARB_ISSUE: if (mdio_req_ready) state_q <= ARB_BUSY;
        ARB_BUSY:  if (mdio_done) state_q <= ARB_IDLE;
        default:   state_q <= ARB_IDLE;
      endcase
    end
  end

  assign sw_req_ready   = (state_q == ARB_IDLE);
  assign mdio_req_valid = (state_q == ARB_ISSUE);
  assign mdio_req_write = wr_q;
  assign mdio_req_phy   = phy_q;
  assign mdio_req_reg   = reg_q;
  assign mdio_req_wdata = wdata_q;
  assign sw_done   = (state_q == ARB_BUSY) && mdio_done && (owner_q == OWN_SW);
  assign poll_done = (state_q == ARB_BUSY) && mdio_done && (owner_q == OWN_POLL);
endmodule

// File: rtl/phy_status_shadow.sv
module phy_status_shadow #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en,
  input  logic              poll_done,
  input  logic [DATA_W-1:0] rdata,
  input  logic              rd_err,
  input  logic              change_clr,
  output logic [DATA_W-1:0] shadow,
  output logic              change_flag
);
  logic primed_q;
  logic good_rd;
  logic diff_seen;

  assign good_rd   = poll_en && poll_done && !rd_err;
  assign diff_seen = good_rd && primed_q && (rdata != shadow);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      shadow   <= '0;
    end else if (!poll_en) begin
      primed_q <= 1'b0;
    end else if (good_rd) begin
      primed_q <= 1'b1;
      shadow   <= rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      change_flag <= 1'b0;
    end else if (diff_seen) begin
      change_flag <= 1'b1;
    end else if (change_clr) begin
      change_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/phy_autopoll.sv
module phy_autopoll
  import phy_autopoll_pkg::*;
#(
  parameter int ADDR_W  = PHY_ADDR_W,
  parameter int DATA_W  = PHY_DATA_W,
  parameter int IVL_W   = PHY_IVL_W,
  parameter int STS_REG = PHY_STS_REG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              poll_en,
  input  logic              irq_en,
  input  logic [ADDR_W-1:0] phy_addr,
  input  logic [IVL_W-1:0]  poll_interval,
  input  logic              change_clr,
  input  logic              sw_req_valid,
  output logic              sw_req_ready,
  input  logic              sw_req_write,
  input  logic [ADDR_W-1:0] sw_req_reg,
  input  logic [DATA_W-1:0] sw_req_wdata,
  output logic              sw_done,
  output logic              mdio_req_valid,
  input  logic              mdio_req_ready,
  output logic              mdio_req_write,
  output logic [ADDR_W-1:0] mdio_req_phy,
  output logic [ADDR_W-1:0] mdio_req_reg,
  output logic [DATA_W-1:0] mdio_req_wdata,
  input  logic              mdio_done,
  input  logic [DATA_W-1:0] mdio_rdata,
  input  logic              mdio_err,
  output logic [DATA_W-1:0] status_shadow,
  output logic              change_flag,
  output logic              irq
);
  logic poll_due;
  logic poll_done;

  phy_poll_timer #(.IVL_W(IVL_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .poll_en  (poll_en),
    .reload   (poll_done),
    .interval (poll_interval),
    .poll_due (poll_due)
  );

  phy_mdio_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STS_REG(STS_REG)) u_arb (
    .clk            (clk),
    .rst_n          (rst_n),
    .sw_req_valid   (sw_req_valid),
    .sw_req_ready   (sw_req_ready),
    .sw_req_write   (sw_req_write),
    .sw_req_reg     (sw_req_reg),
    .sw_req_wdata   (sw_req_wdata),
    .sw_done        (sw_done),
    .poll_due       (poll_due),
    .phy_addr       (phy_addr),
    .mdio_req_valid (mdio_req_valid),
    .mdio_req_ready (mdio_req_ready),
    .mdio_req_write (mdio_req_write),
    .mdio_req_phy   (mdio_req_phy),
    .mdio_req_reg   (mdio_req_reg),
    .mdio_req_wdata (mdio_req_wdata),
    .mdio_done      (mdio_done),
    .poll_done      (poll_done)
  );

  phy_status_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .poll_en     (poll_en),
    .poll_done   (poll_done),
    .rdata       (mdio_rdata),
    .rd_err      (mdio_err),
    .change_clr  (change_clr),
    .shadow      (status_shadow),
    .change_flag (change_flag)
  );

  assign irq = change_flag && irq_en;
endmodule

// File: rtl/phy_autopoll_checker.sv
module phy_autopoll_checker #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              poll_en,
  input logic              irq_en,
  input logic              mdio_req_valid,
  input logic              mdio_req_ready,
  input logic              mdio_req_write,
  input logic [ADDR_W-1:0] mdio_req_reg,
  input logic [DATA_W-1:0] mdio_req_wdata,
  input logic              mdio_done,
  input logic              mdio_err,
  input logic [DATA_W-1:0] status_shadow,
  input logic              change_flag,
  input logic              irq
);
  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req_valid && !mdio_req_ready) |=> (mdio_req_valid && $stable(mdio_req_write)
      && $stable(mdio_req_reg) && $stable(mdio_req_wdata)));

  assert_shadow_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status_shadow) |-> $past(mdio_done && !mdio_err && poll_en));

  assert_flag_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(change_flag) |-> $past(mdio_done && !mdio_err && poll_en));

  assert_no_set_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |=> !$rose(change_flag));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> change_flag);
endmodule

bind phy_autopoll phy_autopoll_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .poll_en        (poll_en),
  .irq_en         (irq_en),
  .mdio_req_valid (mdio_req_valid),
  .mdio_req_ready (mdio_req_ready),
  .mdio_req_write (mdio_req_write),
  .mdio_req_reg   (mdio_req_reg),
  .mdio_req_wdata (mdio_req_wdata),
  .mdio_done      (mdio_done),
  .mdio_err       (mdio_err),
  .status_shadow  (status_shadow),
  .change_flag    (change_flag),
  .irq            (irq)
);

// File: tb/phy_autopoll_bench.sv
module phy_autopoll_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_en = 1'b0;
  logic        irq_en = 1'b0;
  logic [4:0]  phy_addr = 5'h0A;
  logic [15:0] poll_interval = 16'd3;
  logic        change_clr = 1'b0;
  logic        sw_req_valid = 1'b0;
  logic        sw_req_ready;
  logic        sw_req_write = 1'b0;
  logic [4:0]  sw_req_reg = '0;
  logic [15:0] sw_req_wdata = '0;
  logic        sw_done;
  logic        mdio_req_valid;
  logic        mdio_req_ready = 1'b1;
  logic        mdio_req_write;
  logic [4:0]  mdio_req_phy;
  logic [4:0]  mdio_req_reg;
  logic [15:0] mdio_req_wdata;
  logic        mdio_done = 1'b0;
  logic [15:0] mdio_rdata = '0;
  logic        mdio_err = 1'b0;
  logic [15:0] status_shadow;
  logic        change_flag;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 1'b0;

  logic        got_write;
  logic [4:0]  got_phy;
  logic [4:0]  got_reg;
  logic [15:0] got_wdata;

  always #2 clk = ~clk;

  phy_autopoll u_phy_autopoll (
    .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .irq_en(irq_en),
    .phy_addr(phy_addr), .poll_interval(poll_interval), .change_clr(change_clr),
    .sw_req_valid(sw_req_valid), .sw_req_ready(sw_req_ready),
    .sw_req_write(sw_req_write), .sw_req_reg(sw_req_reg),
    .sw_req_wdata(sw_req_wdata), .sw_done(sw_done),
    .mdio_req_valid(mdio_req_valid), .mdio_req_ready(mdio_req_ready),
    .mdio_req_write(mdio_req_write), .mdio_req_phy(mdio_req_phy),
    .mdio_req_reg(mdio_req_reg), .mdio_req_wdata(mdio_req_wdata),
    .mdio_done(mdio_done), .mdio_rdata(mdio_rdata), .mdio_err(mdio_err),
    .status_shadow(status_shadow), .change_flag(change_flag), .irq(irq)
  );

  // vector: {clr_with_done, err, read data, expected shadow, expected flag}
  localparam int NVEC = 6;
  localparam logic [34:0] VECS [NVEC] = '{
    {1'b0, 1'b0, 16'h7809, 16'h7809, 1'b0},
    {1'b0, 1'b0, 16'h7809, 16'h7809, 1'b0},
    {1'b0, 1'b0, 16'h782D, 16'h782D, 1'b1},
    {1'b1, 1'b0, 16'h782D, 16'h782D, 1'b0},
    {1'b0, 1'b1, 16'h0000, 16'h782D, 1'b0},
    {1'b0, 1'b0, 16'h7829, 16'h7829, 1'b1}
  };

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; serves one request as the MDIO master.
  task automatic serve(input logic [15:0] data, input logic err, input logic clr,
                       output int gap, output logic sw_seen);
    gap = 0;
    while (!mdio_req_valid && gap < 1000) begin
      @(negedge clk);
      gap++;
    end
    got_write = mdio_req_write;
    got_phy   = mdio_req_phy;
    got_reg   = mdio_req_reg;
    got_wdata = mdio_req_wdata;
    @(posedge clk);
    @(negedge clk);
    mdio_done  = 1'b1;
    mdio_rdata = data;
    mdio_err   = err;
    change_clr = clr;
    #1 sw_seen = sw_done;
    @(posedge clk);
    @(negedge clk);
    mdio_done  = 1'b0;
    mdio_err   = 1'b0;
    change_clr = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      report();
    end
  end

  initial begin
    int gap;
    logic sws;
    int seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 shadow", 32'(status_shadow), 32'h0);
    check("R1 flag", 32'(change_flag), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 valid", 32'(mdio_req_valid), 32'h0);
    check("R1 ready", 32'(sw_req_ready), 32'h1);

    poll_en = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NVEC; i++) begin
      serve(VECS[i][32:17], VECS[i][33], VECS[i][34], gap, sws);
      if (i == 0) begin
        check("R2 write", 32'(got_write), 32'h0);
        check("R2 phy", 32'(got_phy), 32'h0A);
        check("R2 reg", 32'(got_reg), 32'h01);
        check("R2 first poll immediate", 32'(gap), 32'h0);
      end else begin
        check("R3 gap", 32'(gap), 32'd4);
      end
      if (i == 0) check("R4 store only", 32'(change_flag), 32'h0);
      if (i == 4) check("R6 err poll", 32'(status_shadow), 32'h782D);
      if (i == 3) check("R7 clear", 32'(change_flag), 32'h0);
      check("R5 shadow vec", 32'(status_shadow), 32'(VECS[i][16:1]));
      check("R5 flag vec", 32'(change_flag), 32'(VECS[i][0]));
      check("R10 no sw_done on poll", 32'(sws), 32'h0);
    end

    // R8 interrupt gating
    check("R8 irq masked", 32'(irq), 32'h0);
    irq_en = 1'b1;
    #1 check("R8 irq on", 32'(irq), 32'h1);

    // R11 back-pressure
    mdio_req_ready = 1'b0;
    seen = 0;
    while (!mdio_req_valid && seen < 100) begin @(negedge clk); seen++; end
    got_reg = mdio_req_reg;
    repeat (3) @(negedge clk);
    check("R11 valid held", 32'(mdio_req_valid), 32'h1);
    check("R11 reg held", 32'(mdio_req_reg), 32'(got_reg));
    mdio_req_ready = 1'b1;
    serve(16'h7829, 1'b0, 1'b0, gap, sws);
    check("R11 served", 32'(status_shadow), 32'h7829);

    // R7 set wins over clear in the same cycle
    serve(16'h7000, 1'b0, 1'b1, gap, sws);
    check("R7 set wins", 32'(change_flag), 32'h1);
    serve(16'h7000, 1'b0, 1'b1, gap, sws);
    check("R7 cleared", 32'(change_flag), 32'h0);
    check("R8 irq follows flag", 32'(irq), 32'h0);

    // R9 disable stops polling
    poll_en = 1'b0;
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (mdio_req_valid) seen++;
    end
    check("R9 no polls while off", 32'(seen), 32'h0);

    // R10 software read while disabled
    sw_req_valid = 1'b1; sw_req_write = 1'b0; sw_req_reg = 5'h02;
    @(posedge clk);
    @(negedge clk);
    sw_req_valid = 1'b0;
    serve(16'h0141, 1'b0, 1'b0, gap, sws);
    check("R10 sw reg", 32'(got_reg), 32'h02);
    check("R10 sw_done", 32'(sws), 32'h1);
    check("R10 shadow untouched", 32'(status_shadow), 32'h7000);

    // R10 priority: software and due poll in the same cycle
    check("R10 ready idle", 32'(sw_req_ready), 32'h1);
    poll_en = 1'b1;
    sw_req_valid = 1'b1; sw_req_write = 1'b1; sw_req_reg = 5'h04; sw_req_wdata = 16'hBEEF;
    @(posedge clk);
    @(negedge clk);
    sw_req_valid = 1'b0;
    serve(16'h0000, 1'b0, 1'b0, gap, sws);
    check("R10 prio write", 32'(got_write), 32'h1);
    check("R10 prio reg", 32'(got_reg), 32'h04);
    check("R10 prio wdata", 32'(got_wdata), 32'hBEEF);
    check("R10 prio done", 32'(sws), 32'h1);

    // R9 re-enable restarts with a load-only read
    serve(16'hAAAA, 1'b0, 1'b0, gap, sws);
    check("R9 poll after sw", 32'(got_reg), 32'h01);
    check("R9 reload shadow", 32'(status_shadow), 32'hAAAA);
    check("R9 store only flag", 32'(change_flag), 32'h0);
    serve(16'hAAAB, 1'b0, 1'b0, gap, sws);
    check("R5 change after rearm", 32'(change_flag), 32'h1);
    check("R8 irq asserted", 32'(irq), 32'h1);

    report();
  end
endmodule